// File: doc/BRIEF.md
# Page Access Permission and Fault-Code Unit

This unit sits at the end of a page-table walk. It receives the bits of the final leaf entry and the user, writable and no-execute bits already combined across all levels of the walk. It also receives the kind of access, the privilege of the requester and the paging control enables. From these it decides whether the access may proceed.

When the access is granted, the unit returns the read, write and execute rights that a translation cache may store for the page. When the access is refused, it returns the page-fault error code. The walker reports not-present and reserved-bit conditions on two flag inputs, and the unit folds them into the same code. Each decision is registered and appears one cycle after its request.

Protection keys are an elaboration option. A 4-bit key taken from the entry selects two bits of a 32-bit rights word. One bit removes read and write access. The other removes write access only.

Top module: `pa_access_check`

## Requirements
- R1: A user-mode access (`acc_user`=1) to an entry whose combined user bit is 0 is refused with a protection fault: error-code bit 0 is set and bit 5 is clear, even if the key check would also refuse it.
- R2: Write right is granted when the combined writable bit is 1, or when the access is supervisor mode and `cfg_wp`=0. Otherwise a write access (`acc_type`=2'b01) is refused.
- R3: Execute right is withheld when the combined no-execute bit is 1. It is also withheld for a supervisor access to a user page when `cfg_sxp`=1. A fetch (`acc_type`=2'b10) without execute right is refused.
- R4: The key check applies only when `cfg_pke`=1, the page is a user page and `key_rights` is nonzero. When it applies, `key_rights[2*key]`=1 removes read and write rights. A read (`acc_type` 2'b00 or 2'b11) or a write is then refused.
- R5: Under an active key check, `key_rights[2*key+1]`=1 removes write right for user accesses, and for supervisor accesses only when `cfg_wp`=1.
- R6: A refusal caused by the key check sets error-code bit 5 together with bit 0.
- R7: Fault priority is not-present first, then reserved-bit, then protection. A not-present fault leaves bits 0 and 3 clear. A reserved-bit fault sets both bit 0 and bit 3. A protection fault sets bit 0 and leaves bit 3 clear.
- R8: On every fault, bit 1 is set for writes and bit 2 for user accesses. Bit 4 is set for fetches only when `cfg_nxe` and `cfg_pae` are both 1, or when `cfg_sxp`=1.
- R9: A granted non-write access to an entry whose dirty bit is 0 reports `perm_w`=0.
- R10: A granted access reports an error code of 0. A refused access reports `perm_r`, `perm_w` and `perm_x` all 0.
- R11: Outputs update on the clock edge that samples `req_valid`=1, with `rsp_valid`=1. Without a request, `rsp_valid` is 0. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| acc_type | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| acc_user | input | 1 | Access made in user mode |
| ent_user | input | 1 | Combined user bit of the walk |
| ent_write | input | 1 | Combined writable bit of the walk |
| ent_nx | input | 1 | Combined no-execute bit of the walk |
| ent_dirty | input | 1 | Dirty bit of the leaf entry |
| ent_key | input | 4 | Protection key of the leaf entry |
| walk_nopres | input | 1 | Walker found a non-present entry |
| walk_rsvd | input | 1 | Walker found reserved bits set |
| cfg_wp | input | 1 | Supervisor write protection enable |
| cfg_nxe | input | 1 | No-execute enable |
| cfg_pae | input | 1 | Wide-entry paging enabled |
| cfg_sxp | input | 1 | Supervisor-execute protection enable |
| cfg_pke | input | 1 | Protection keys enable |
| key_rights | input | 32 | Per-key access/write disable pairs |
| rsp_valid | output | 1 | Decision valid |
| allow | output | 1 | Access granted |
| perm_r | output | 1 | Cacheable read right |
| perm_w | output | 1 | Cacheable write right |
| perm_x | output | 1 | Cacheable execute right |
| fault_code | output | 6 | Page-fault error code |

## Verification
The bench goes after the cases where two rules overlap. One is a user access to a supervisor page whose key is also disabled: a design that checks keys first would set bit 5 wrongly. Another is a supervisor write under a write-disabled key with write protection off: a design that ignores `cfg_wp` there would refuse a legal write. It also checks fetch-fault codes with every enable combination, because a design that always sets bit 4 breaks older software. It checks that clean pages come back without write right, because a design that keeps it would let a later write skip setting the dirty bit. Finally, it checks the priority of not-present over reserved-bit faults, which shows up as whether bit 0 is set.

// File: rtl/pa_pkg.sv
package pa_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RD2   = 2'b11
   } acc_e;

   localparam int EC_W    = 6;
   localparam int EC_P    = 0;
   localparam int EC_WR   = 1;
   localparam int EC_USR  = 2;
   localparam int EC_RSVD = 3;
   localparam int EC_IF   = 4;
   localparam int EC_PK   = 5;
endpackage

// File: rtl/pa_base_perm.sv
module pa_base_perm (
   input  logic acc_user,
   input  logic ent_user,
   input  logic ent_write,
   input  logic ent_nx,
   input  logic cfg_wp,
   input  logic cfg_sxp,
   output logic br,
   output logic bw,
   output logic bx,
   output logic user_fault
);
   always_comb begin
      user_fault = acc_user & ~ent_user;
      br         = 1'b1;
      bw         = ent_write | (~acc_user & ~cfg_wp);
      bx         = ~ent_nx & (acc_user | ~(cfg_sxp & ent_user));
   end
endmodule

// File: rtl/pa_key_rights.sv
module pa_key_rights #(
   parameter int KEY_W = 4,
   localparam int NKEYS = 1 << KEY_W,
   localparam int RW    = 2 * NKEYS
) (
   input  logic             active,
   input  logic [KEY_W-1:0] key,
   input  logic [RW-1:0]    rights,
   input  logic             acc_user,
   input  logic             cfg_wp,
   output logic             kr,
   output logic             kw
);
   logic [NKEYS-1:0] ad_vec, wd_vec;
   logic             ad, wd;

   for (genvar k = 0; k < NKEYS; k++) begin : g_split
      assign ad_vec[k] = rights[2*k];
      assign wd_vec[k] = rights[2*k+1];
   end

   always_comb begin
      ad = ad_vec[key];
      wd = wd_vec[key];
      kr = ~(active & ad);
      kw = ~(active & (ad | (wd & (acc_user | cfg_wp))));
   end
endmodule

// File: rtl/pa_code_build.sv
module pa_code_build
   import pa_pkg::*;
(
   input  logic            nopres,
   input  logic            rsvd,
   input  logic            prot,
   input  logic            pk,
   input  logic            is_write,
   input  logic            is_fetch,
   input  logic            acc_user,
   input  logic            cfg_nxe,
   input  logic            cfg_pae,
   input  logic            cfg_sxp,
   output logic [EC_W-1:0] code
);
   logic any_fault;

   always_comb begin
      any_fault      = nopres | rsvd | prot;
      code           = '0;
      code[EC_P]     = ~nopres & (rsvd | prot);
      code[EC_RSVD]  = ~nopres & rsvd;
      code[EC_PK]    = ~nopres & ~rsvd & prot & pk;
      code[EC_WR]    = any_fault & is_write;
      code[EC_USR]   = any_fault & acc_user;
      code[EC_IF]    = any_fault & is_fetch & ((cfg_nxe & cfg_pae) | cfg_sxp);
   end
endmodule

// File: rtl/pa_access_check.sv
module pa_access_check
   import pa_pkg::*;
#(
   parameter int KEY_W   = 4,
   parameter bit KEYS_EN = 1'b1,
   localparam int RW     = 2 * (1 << KEY_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       acc_type,
   input  logic             acc_user,
   input  logic             ent_user,
   input  logic             ent_write,
   input  logic             ent_nx,
   input  logic             ent_dirty,
   input  logic [KEY_W-1:0] ent_key,
   input  logic             walk_nopres,
   input  logic             walk_rsvd,
   input  logic             cfg_wp,
   input  logic             cfg_nxe,
   input  logic             cfg_pae,
   input  logic             cfg_sxp,
   input  logic             cfg_pke,
   input  logic [RW-1:0]    key_rights,
   output logic             rsp_valid,
   output logic             allow,
   output logic             perm_r,
   output logic             perm_w,
   output logic             perm_x,
   output logic [EC_W-1:0]  fault_code
);
   if (KEY_W < 1 || KEY_W > 5) begin : g_bad_key_w
      $error("pa_access_check: KEY_W must lie in 1..5");
   end

   logic            is_write, is_fetch;
   logic            br, bw, bx, user_fault;
   logic            kr, kw, key_on;
   logic            r_f, w_f, x_f, key_deny, base_deny, prot, grant;
   logic [EC_W-1:0] code_n;

   assign is_write = (acc_type == ACC_WRITE);
   assign is_fetch = (acc_type == ACC_FETCH);

   pa_base_perm u_base (
      .acc_user  (acc_user),
      .ent_user  (ent_user),
      .ent_write (ent_write),
      .ent_nx    (ent_nx),
      .cfg_wp    (cfg_wp),
      .cfg_sxp   (cfg_sxp),
      .br        (br),
      .bw        (bw),
      .bx        (bx),
      .user_fault(user_fault)
   );

   if (KEYS_EN) begin : g_keys
      assign key_on = cfg_pke & ent_user & (|key_rights);
      pa_key_rights #(.KEY_W(KEY_W)) u_keys (
         .active  (key_on),
         .key     (ent_key),
         .rights  (key_rights),
         .acc_user(acc_user),
         .cfg_wp  (cfg_wp),
         .kr      (kr),
         .kw      (kw)
      );
   end else begin : g_nokeys
      assign key_on = 1'b0;
      assign kr     = 1'b1;
      assign kw     = 1'b1;
   end

   always_comb begin
      r_f       = br & kr;
      w_f       = bw & kw;
      x_f       = bx;
      key_deny  = is_write ? ~kw : (is_fetch ? 1'b0 : ~kr);
      base_deny = is_write ? ~w_f : (is_fetch ? ~x_f : ~r_f);
      prot      = user_fault | key_deny | base_deny;
      grant     = ~(walk_nopres | walk_rsvd | prot);
   end

   pa_code_build u_code (
      .nopres  (walk_nopres),
      .rsvd    (walk_rsvd),
      .prot    (prot),
      .pk      (key_deny & ~user_fault),
      .is_write(is_write),
      .is_fetch(is_fetch),
      .acc_user(acc_user),
      .cfg_nxe (cfg_nxe),
      .cfg_pae (cfg_pae),
      .cfg_sxp (cfg_sxp),
      .code    (code_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         allow      <= 1'b0;
         perm_r     <= 1'b0;
         perm_w     <= 1'b0;
         perm_x     <= 1'b0;
         fault_code <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            allow      <= grant;
            perm_r     <= grant & r_f;
            perm_w     <= grant & w_f & (ent_dirty | is_write);
            perm_x     <= grant & x_f;
            fault_code <= code_n;
         end
      end
   end

   AST_USER_PAGE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(acc_user && !ent_user) |-> !allow && !fault_code[EC_PK]); // R1
   AST_RSVD_HAS_P: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && fault_code[EC_RSVD] |-> fault_code[EC_P]); // R7
   AST_PK_WITH_P: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && fault_code[EC_PK] |-> fault_code[EC_P] && !allow); // R6
   AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && allow |-> fault_code == '0); // R10
   AST_DENY_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !allow |-> !perm_r && !perm_w && !perm_x); // R10
   AST_FETCH_HAS_X: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && allow && $past(acc_type == ACC_FETCH) |-> perm_x); // R3
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(req_valid)); // R11
endmodule

// File: tb/sim_pa_access_check.sv
module sim_pa_access_check;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  acc_type = 2'b00;
   logic        acc_user = 1'b0, ent_user = 1'b0, ent_write = 1'b0, ent_nx = 1'b0;
   logic        ent_dirty = 1'b0;
   logic [3:0]  ent_key = 4'd0;
   logic        walk_nopres = 1'b0, walk_rsvd = 1'b0;
   logic        cfg_wp = 1'b0, cfg_nxe = 1'b0, cfg_pae = 1'b0, cfg_sxp = 1'b0, cfg_pke = 1'b0;
   logic [31:0] key_rights = 32'd0;
   logic        rsp_valid, allow, perm_r, perm_w, perm_x;
   logic [5:0]  fault_code;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   pa_access_check u0 (.*);

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not end (actual hung, expected finish)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   // expected result packed as {valid, allow, r, w, x, code[5:0]}
   function automatic logic [10:0] model();
      int  rd, wr, fx;
      bit  ok_r, ok_w, ok_x, keyed, kdeny, udeny, need, pkb;
      int  code;
      wr = (acc_type == 2'd1);
      fx = (acc_type == 2'd2);
      rd = !wr && !fx;
      ok_r = 1;
      ok_w = ent_write || (!acc_user && !cfg_wp);
      ok_x = !ent_nx;
      if (fx && !acc_user && cfg_sxp && ent_user) ok_x = 0;
      keyed = cfg_pke && ent_user && (key_rights != 0);
      kdeny = 0;
      if (keyed) begin
         if (key_rights[ent_key*2]) begin
            ok_r = 0; ok_w = 0;
            if (!fx) kdeny = 1;
         end else if (key_rights[ent_key*2+1] && (acc_user || cfg_wp)) begin
            ok_w = 0;
            if (wr) kdeny = 1;
         end
      end
      if (!ent_nx && !(!acc_user && cfg_sxp && ent_user)) ok_x = 1; else ok_x = 0;
      udeny = acc_user && !ent_user;
      need = (rd && !ok_r) || (wr && !ok_w) || (fx && !ok_x) || udeny;
      pkb = kdeny && !udeny;
      code = 0;
      if (walk_nopres || walk_rsvd || need) begin
         if (wr) code += 2;
         if (acc_user) code += 4;
         if (fx && ((cfg_nxe && cfg_pae) || cfg_sxp)) code += 16;
         if (!walk_nopres) begin
            code += 1;
            if (walk_rsvd) code += 8;
            else if (pkb) code += 32;
         end
         return {1'b1, 4'b0000, code[5:0]};
      end
      return {1'b1, 1'b1, ok_r, ok_w && (ent_dirty || wr), ok_x, 6'd0};
   endfunction

   function automatic string tag_of();
      if (walk_nopres || walk_rsvd) return "R7";
      if (acc_user && !ent_user) return "R1";
      if (cfg_pke && ent_user && key_rights != 0) return (acc_type == 2'd1) ? "R5" : "R4";
      if (acc_type == 2'd2) return "R3";
      if (acc_type == 2'd1) return "R2";
      if (!ent_dirty) return "R9";
      return "R10";
   endfunction

   task automatic compare(input logic [10:0] exp, input string tag);
      logic [10:0] act;
      act = {rsp_valid, allow, perm_r, perm_w, perm_x, fault_code};
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual v=%b a=%b rwx=%b%b%b code=%06b, expected v=%b a=%b rwx=%b code=%06b",
                  tag, act[10], act[9], act[8], act[7], act[6], act[5:0],
                  exp[10], exp[9], exp[8:6], exp[5:0]);
      end
   endtask

   // drive a vector at a falling edge, check it at the next falling edge
   task automatic step(input string tag);
      logic [10:0] exp;
      string       t;
      req_valid = 1'b1;
      exp = model();
      t = (tag == "") ? tag_of() : tag;
      @(negedge clk);
      compare(exp, t);
   endtask

   task automatic setv(input logic [1:0] at, input bit au, input bit eu, input bit ew,
                       input bit enx, input bit ed, input bit np, input bit rs);
      acc_type = at; acc_user = au; ent_user = eu; ent_write = ew;
      ent_nx = enx; ent_dirty = ed; walk_nopres = np; walk_rsvd = rs;
   endtask

   task automatic setc(input bit wp, input bit nxe, input bit pae, input bit sxp,
                       input bit pke, input logic [31:0] kr, input logic [3:0] k);
      cfg_wp = wp; cfg_nxe = nxe; cfg_pae = pae; cfg_sxp = sxp; cfg_pke = pke;
      key_rights = kr; ent_key = k;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare(11'd0, "R11 reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare(11'd0, "R11 idle");

      // R1: user access to supervisor page, with a disabling key too
      setc(0, 0, 0, 0, 1, 32'h0000_0001, 4'd0);
      setv(2'd0, 1, 0, 1, 0, 1, 0, 0); step("R1");
      if (fault_code !== 6'b000101) begin n_bad++;
         $display("FAIL R1: actual code=%06b expected 000101", fault_code); end
      n_cmp++;
      // R2: supervisor write to read-only page, wp off then on
      setc(0, 0, 0, 0, 0, 0, 0);
      setv(2'd1, 0, 0, 0, 0, 1, 0, 0); step("R2 wp off");
      cfg_wp = 1; step("R2 wp on");
      // R3: nx fetch, and supervisor fetch from user page with sxp
      setc(0, 1, 1, 0, 0, 0, 0);
      setv(2'd2, 0, 1, 1, 1, 1, 0, 0); step("R3 nx");
      setv(2'd2, 0, 1, 1, 0, 1, 0, 0); step("R3 sxp off");
      cfg_sxp = 1; step("R3 sxp on");
      // R4: access-disable on key 7 (bit 14)
      setc(0, 0, 0, 0, 1, 32'h0000_4000, 4'd7);
      setv(2'd3, 1, 1, 1, 0, 1, 0, 0); step("R4 read");
      ent_key = 4'd6; step("R4 other key");
      cfg_pke = 0; ent_key = 4'd7; step("R4 pke off");
      // R5: write-disable on key 15 (bit 31), supervisor with/without wp
      setc(0, 0, 0, 0, 1, 32'h8000_0000, 4'd15);
      setv(2'd1, 0, 1, 1, 0, 1, 0, 0); step("R5 sup wp off");
      cfg_wp = 1; step("R5 sup wp on");
      acc_user = 1; cfg_wp = 0; step("R6 user wd");
      // R7: priority and reserved
      setc(0, 0, 0, 0, 0, 0, 0);
      setv(2'd1, 1, 0, 0, 0, 1, 1, 1); step("R7 nopres");
      setv(2'd1, 1, 0, 0, 0, 1, 0, 1); step("R7 rsvd");
      // R8: fetch bit under enables
      setv(2'd2, 1, 1, 1, 1, 1, 1, 0);
      setc(0, 1, 0, 0, 0, 0, 0); step("R8 nxe only");
      setc(0, 1, 1, 0, 0, 0, 0); step("R8 nxe pae");
      setc(0, 0, 0, 1, 0, 0, 0); step("R8 sxp");
      // R9: clean page read and write
      setc(0, 0, 0, 0, 0, 0, 0);
      setv(2'd0, 1, 1, 1, 0, 0, 0, 0); step("R9 clean read");
      acc_type = 2'd1; step("R9 clean write");
      // R11: no request holds rsp_valid low
      req_valid = 1'b0;
      @(negedge clk);
      n_cmp++;
      if (rsp_valid !== 1'b0) begin n_bad++;
         $display("FAIL R11: actual rsp_valid=%b expected 0", rsp_valid); end

      for (int i = 0; i < 4000; i++) begin
         logic [31:0] a = $urandom, b = $urandom;
         setv(a[1:0], a[2], a[3], a[4], a[5], a[6], a[7] & a[8] & a[9], a[10] & a[11] & a[12]);
         setc(a[13], a[14], a[15], a[16], a[17], (a[18] ? 32'd0 : b), a[22:19]);
         step("");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule